// File: doc/BRIEF.md
# Wave-Table Column Timing Sequencer

This block produces a set of control levels for a line-based readout from a small programmable table. Each table word pairs a column position with a control pattern. A column counter runs along each row. The entry the sequencer is waiting on is compared with that counter, and on a match its pattern is registered onto the outputs. The sequencer then moves on to the next entry.

Software fills the table through a single write port while counting is held off. Each row is started with a one-cycle row-start pulse. The pulse reloads the counter from a begin column and rewinds the sequencer to the first entry. Once the counter reaches the end column, the outputs freeze until the next row start.

A select input swaps the table for a fixed four-step test waveform. Another input chooses whether the counter stops at the last physical column or keeps running and wraps.

Top module: `wt_col_sequencer`

## Requirements
- R1: After reset, `ctlOut` and `colPos` are 0. Nothing changes until the first row-start pulse taken with `cntEn` high, apart from `colPos` counting while `cntEn` is high.
- R2: A write puts `tblWrData` into entry `tblWrAddr`. The write takes effect only when `tblWrEn` is high and `cntEn` is low. A write attempted while `cntEn` is high leaves the table unchanged.
- R3: Bits 9:0 of a table word hold the column position and bits 19:10 hold the control pattern. If the counter equals the current entry's position on a counting cycle, `ctlOut` shows that pattern from the next clock edge, and the current entry moves to the next index.
- R4: Entries are used strictly in index order. If an entry's position is never reached, no later entry is applied in that row.
- R5: A row-start pulse with `cntEn` high loads `colPos` with `beginPos`, makes entry 0 current and clears any freeze. `ctlOut` keeps its value across the pulse. A row-start pulse while `cntEn` is low has no effect.
- R6: On each cycle with `cntEn` high, `colPos` advances by one. While `cntEn` is low, the counter, the current entry and `ctlOut` all hold.
- R7: The cycle on which `colPos` equals `endPos` still applies a matching entry. After that cycle, `ctlOut` does not change until the next row start.
- R8: With `freeRun` low, the counter stops at column 649 and does not advance past it. With `freeRun` high, it keeps counting and wraps from 1023 to 0.
- R9: With `useDefault` high, a fixed list replaces the table. Its entries in order are: column 10 gives pattern 0x001, column 100 gives 0x003, column 300 gives 0x006, and column 600 gives 0x000.
- R10: Once the last entry has been applied (index 31 for the table, index 3 for the fixed list), `ctlOut` holds until the next row start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Count enable; low while loading the table |
| rowStart | input | 1 | One-cycle row-start pulse |
| freeRun | input | 1 | 1: counter wraps; 0: counter stops at column 649 |
| useDefault | input | 1 | 1: fixed test waveform; 0: programmed table |
| beginPos | input | 10 | Column loaded into the counter at row start |
| endPos | input | 10 | Column after which the outputs freeze |
| tblWrEn | input | 1 | Table write strobe |
| tblWrAddr | input | 5 | Table entry index to write |
| tblWrData | input | 20 | Table word: bits 19:10 pattern, bits 9:0 column |
| ctlOut | output | 10 | Registered control pattern |
| colPos | output | 10 | Current column counter value |

## Verification
The bench covers the following corner cases, with the wrong behaviour each one would expose:
- A begin column set past the first entry's position. A sequencer that searched ahead instead of waiting would apply later entries anyway.
- An end column that lands exactly on an entry. Off-by-one freeze logic would either drop that last pattern or let the next one through.
- A row begun at 600 in free-run mode. A counter that saturated would never reach the post-wrap entries, and a wrong wrap would hit them at the wrong cycle.
- Writes attempted while counting, a mid-row pause, and a mid-row restart. These reveal a write port that ignores the count enable, a counter that keeps running when held, or a restart that resets the outputs.

// File: rtl/wt_seq_pkg.sv
package wt_seq_pkg;
  localparam int WT_POS_W   = 10;
  localparam int WT_CTL_W   = 10;
  localparam int WT_ENTRIES = 32;
  localparam int WT_DEF_N   = 4;
  localparam int WT_SAT_COL = 649;

  typedef struct packed {
    logic loadRow;   // rewind to first entry, reload column
    logic apply;     // register current entry's pattern
  } wtStrobe_t;
endpackage

// File: rtl/wt_control.sv
module wt_control
  import wt_seq_pkg::*;
#(
  parameter int POS_W   = WT_POS_W,
  parameter int TBL_N   = WT_ENTRIES,
  parameter int DEF_N   = WT_DEF_N,
  parameter int SAT_COL = WT_SAT_COL,
  parameter int IDX_W   = $clog2(TBL_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cntEn,
  input  logic             rowStart,
  input  logic             freeRun,
  input  logic             useDefault,
  input  logic [POS_W-1:0] beginPos,
  input  logic [POS_W-1:0] endPos,
  input  logic [POS_W-1:0] entryPos,
  output logic [IDX_W-1:0] rdIdx,
  output logic [POS_W-1:0] colPos,
  output wtStrobe_t        strobe
);
  localparam logic [POS_W-1:0] SAT_V = POS_W'(SAT_COL);

  logic [POS_W-1:0] colQ;
  logic [IDX_W-1:0] ptrQ;
  logic             activeQ;
  logic             doneQ;
  logic [IDX_W-1:0] lastIdx;
  logic             colAdvance;

  assign lastIdx    = useDefault ? IDX_W'(DEF_N - 1) : IDX_W'(TBL_N - 1);
  assign colAdvance = freeRun || (colQ < SAT_V);

  always_comb begin
    strobe.loadRow = cntEn && rowStart;
    strobe.apply   = cntEn && !rowStart && activeQ && !doneQ && (entryPos == colQ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colQ    <= '0;
      ptrQ    <= '0;
      activeQ <= 1'b0;
      doneQ   <= 1'b0;
    end else if (cntEn) begin
      if (rowStart) begin
        colQ    <= beginPos;
        ptrQ    <= '0;
        activeQ <= 1'b1;
        doneQ   <= 1'b0;
      end else begin
        if (strobe.apply) begin
          if (ptrQ == lastIdx) doneQ <= 1'b1;
          else                 ptrQ  <= ptrQ + IDX_W'(1);
        end
        if (activeQ && (colQ == endPos)) activeQ <= 1'b0;
        if (colAdvance) colQ <= colQ + POS_W'(1);
      end
    end
  end

  assign rdIdx  = ptrQ;
  assign colPos = colQ;

  AST_ROW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cntEn && rowStart) |=> (colQ == $past(beginPos)) && (ptrQ == '0)); // R5
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cntEn && !rowStart && (colQ < SAT_V)) |=> (colQ == $past(colQ) + POS_W'(1))); // R6
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cntEn |=> $stable(colQ) && $stable(ptrQ)); // R6
  AST_COL_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cntEn && !rowStart && !freeRun && (colQ == SAT_V)) |=> (colQ == SAT_V)); // R8
endmodule

// File: rtl/wt_datapath.sv
module wt_datapath
  import wt_seq_pkg::*;
#(
  parameter int POS_W = WT_POS_W,
  parameter int CTL_W = WT_CTL_W,
  parameter int TBL_N = WT_ENTRIES,
  parameter int IDX_W = $clog2(TBL_N),
  parameter int WORD_W = POS_W + CTL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cntEn,
  input  logic              useDefault,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  input  wtStrobe_t         strobe,
  output logic [POS_W-1:0]  entryPos,
  output logic [CTL_W-1:0]  ctlOut
);
  logic [WORD_W-1:0] tblMem [TBL_N];
  logic [WORD_W-1:0] defWord;
  logic [WORD_W-1:0] curWord;
  logic [CTL_W-1:0]  ctlQ;

  // Fixed test waveform: four transitions across the line
  always_comb begin
    case (rdIdx[1:0])
      2'd0:    defWord = {CTL_W'(10'h001), POS_W'(10)};
      2'd1:    defWord = {CTL_W'(10'h003), POS_W'(100)};
      2'd2:    defWord = {CTL_W'(10'h006), POS_W'(300)};
      default: defWord = {CTL_W'(10'h000), POS_W'(600)};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < TBL_N; e++) tblMem[e] <= '0;
    end else if (wrEn && !cntEn) begin
      tblMem[wrAddr] <= wrData;
    end
  end

  assign curWord  = useDefault ? defWord : tblMem[rdIdx];
  assign entryPos = curWord[POS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ctlQ <= '0;
    else if (strobe.apply) ctlQ <= curWord[WORD_W-1:POS_W];
  end

  assign ctlOut = ctlQ;

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.apply |=> $stable(ctlQ)); // R7
  AST_LOAD_KEEPS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadRow |=> $stable(ctlQ)); // R5
endmodule

// File: rtl/wt_col_sequencer.sv
module wt_col_sequencer
  import wt_seq_pkg::*;
#(
  parameter int POS_W   = WT_POS_W,
  parameter int CTL_W   = WT_CTL_W,
  parameter int TBL_N   = WT_ENTRIES,
  parameter int DEF_N   = WT_DEF_N,
  parameter int SAT_COL = WT_SAT_COL,
  localparam int IDX_W  = $clog2(TBL_N),
  localparam int WORD_W = POS_W + CTL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cntEn,
  input  logic              rowStart,
  input  logic              freeRun,
  input  logic              useDefault,
  input  logic [POS_W-1:0]  beginPos,
  input  logic [POS_W-1:0]  endPos,
  input  logic              tblWrEn,
  input  logic [IDX_W-1:0]  tblWrAddr,
  input  logic [WORD_W-1:0] tblWrData,
  output logic [CTL_W-1:0]  ctlOut,
  output logic [POS_W-1:0]  colPos
);
  wtStrobe_t        strobe;
  logic [IDX_W-1:0] rdIdx;
  logic [POS_W-1:0] entryPos;

  wt_control #(.POS_W(POS_W), .TBL_N(TBL_N), .DEF_N(DEF_N),
               .SAT_COL(SAT_COL), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .rowStart(rowStart),
    .freeRun(freeRun), .useDefault(useDefault), .beginPos(beginPos),
    .endPos(endPos), .entryPos(entryPos), .rdIdx(rdIdx),
    .colPos(colPos), .strobe(strobe));

  wt_datapath #(.POS_W(POS_W), .CTL_W(CTL_W), .TBL_N(TBL_N),
                .IDX_W(IDX_W), .WORD_W(WORD_W)) uData (
    .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .useDefault(useDefault),
    .wrEn(tblWrEn), .wrAddr(tblWrAddr), .wrData(tblWrData),
    .rdIdx(rdIdx), .strobe(strobe), .entryPos(entryPos), .ctlOut(ctlOut));
endmodule

// File: tb/wt_col_sequencer_test.sv
module wt_col_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cntEn = 1'b0;
  logic        rowStart = 1'b0;
  logic        freeRun = 1'b0;
  logic        useDefault = 1'b0;
  logic [9:0]  beginPos = '0;
  logic [9:0]  endPos = 10'd1020;
  logic        tblWrEn = 1'b0;
  logic [4:0]  tblWrAddr = '0;
  logic [19:0] tblWrData = '0;
  logic [9:0]  ctlOut;
  logic [9:0]  colPos;

  wt_col_sequencer uut (.*);

  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string curReq = "R1";

  // behavioural reference
  int mTbl [32];
  int defPos [4] = '{10, 100, 300, 600};
  int defCtl [4] = '{1, 3, 6, 0};
  int mCol, mPtr, mCtl;
  bit mAct, mDone;

  always @(posedge clk) begin
    int n, ep, ec;
    if (!rst_n) begin
      mCol = 0; mPtr = 0; mCtl = 0; mAct = 0; mDone = 0;
      foreach (mTbl[i]) mTbl[i] = 0;
    end else if (!cntEn) begin
      if (tblWrEn) mTbl[tblWrAddr] = int'(tblWrData);
    end else if (rowStart) begin
      mCol = int'(beginPos); mPtr = 0; mAct = 1; mDone = 0;
    end else begin
      n = useDefault ? 4 : 32;
      if (mAct && !mDone) begin
        ep = useDefault ? defPos[mPtr] : (mTbl[mPtr] % 1024);
        ec = useDefault ? defCtl[mPtr] : (mTbl[mPtr] / 1024);
        if (ep == mCol) begin
          mCtl = ec;
          mPtr++;
          if (mPtr == n) mDone = 1;
        end
      end
      if (mAct && mCol == int'(endPos)) mAct = 0;
      if (freeRun || mCol < 649) mCol = (mCol + 1) % 1024;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (int'(ctlOut) != mCtl || int'(colPos) != mCol) begin
      fails++;
      $display("FAIL %s t=%0t: ctlOut=%0h colPos=%0d expected ctlOut=%0h colPos=%0d",
               curReq, $time, ctlOut, colPos, mCtl, mCol);
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected under 150000", cyc);
      summary();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeEntry(int idx, logic [19:0] data);
    tblWrEn = 1'b1; tblWrAddr = 5'(idx); tblWrData = data;
    step(1);
    tblWrEn = 1'b0;
  endtask

  task automatic startRow(int b, int e);
    beginPos = 10'(b); endPos = 10'(e); rowStart = 1'b1;
    step(1);
    rowStart = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    curReq = "R1";          // idle after reset, then counting without a row
    step(5);
    cntEn = 1'b1;
    step(20);
    cntEn = 1'b0;

    curReq = "R2";          // load table while counting is off
    for (int i = 0; i < 32; i++)
      writeEntry(i, {10'((i * 37 + 1) % 1024), 10'(5 * (i + 1))});
    rowStart = 1'b1;        // R5: ignored while cntEn low
    step(2);
    rowStart = 1'b0;
    cntEn = 1'b1;
    writeEntry(0, {10'h3AA, 10'd7});   // R2: blocked while counting

    curReq = "R3";          // full row, all 32 entries, then stop at 649
    startRow(0, 1020);
    step(80);
    curReq = "R6";          // pause mid-row
    cntEn = 1'b0;
    step(20);
    cntEn = 1'b1;
    curReq = "R10";
    step(600);
    curReq = "R8";
    step(20);

    curReq = "R4";          // begin past first entry: sequence stalls
    startRow(50, 1020);
    step(300);

    curReq = "R7";          // end lands exactly on entry 7 (column 40)
    startRow(0, 40);
    step(200);

    curReq = "R8";          // free-run wrap, entries hit after wrap
    freeRun = 1'b1;
    startRow(600, 100);
    step(600);
    freeRun = 1'b0;

    curReq = "R9";          // fixed test waveform
    useDefault = 1'b1;
    startRow(0, 1020);
    step(700);
    useDefault = 1'b0;

    curReq = "R5";          // restart mid-row keeps ctlOut
    startRow(0, 1020);
    step(100);
    startRow(20, 1020);
    step(200);

    summary();
  end
endmodule